// File: doc/BRIEF.md
# BCD Lap Timer with Lap Store

This block is a decimal seconds counter whose count is held as three separate BCD digits (hundreds, tens, ones), so the count runs from 000 to 999. A one-cycle tick enable, pulsed once per second by a prescaler elsewhere in the chip, advances the count by one. The live digits are always visible on one packed output, ready for a display driver.

A stop input freezes the counter. The first cycle in which stop is seen high, the three frozen digits are written into a small lap memory. The slot is the one named by a lap index from outside the block, so a supervising sequencer can file each lap under its own number. A separate read index selects any slot, and that slot's stored digits appear combinationally on a read-back output. Lowering stop lets the count resume from where it froze.

Top module: `lapTimer`

## Requirements
- R1: A synchronous reset (rst high at a rising clk edge) clears the live count to 000 and every lap slot to 000.
- R2: The packed BCD layout is ones in bits [3:0], tens in [7:4] and hundreds in [11:8], on both liveBcd and rdBcd. With stop low, a clock edge with tick high adds one to the count, and a clock edge with tick low leaves the count unchanged.
- R3: When the ones digit is 9, an advancing tick sets ones to 0 and adds one to tens.
- R4: When tens and ones are both 9, an advancing tick sets both to 0 and adds one to hundreds.
- R5: From 999, an advancing tick wraps the count to 000.
- R6: While stop is high, tick has no effect and the live count holds.
- R7: On the first clock edge at which stop is high after being low (or after reset), the current live digits are written to slot lapIdx. They are readable from the following cycle onward.
- R8: Holding stop high for further edges writes nothing more, even if lapIdx changes.
- R9: rdBcd shows the slot chosen by rdIdx in the same cycle. Slots that were not written keep their contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-second advance enable |
| stop | input | 1 | Freeze count; rising level captures a lap |
| lapIdx | input | 3 | Slot written on capture |
| rdIdx | input | 3 | Slot shown on rdBcd |
| liveBcd | output | 12 | Live count, three BCD digits |
| rdBcd | output | 12 | Digits stored in slot rdIdx |

## Verification
The bench drives the count across each carry boundary: 009 to 010, 099 to 100 and 999 to 000. A design with a broken carry chain would show a hex digit such as A, would fail to clear the lower digits, or would skip the wrap. It pulses tick while stop is high, which catches a counter that keeps running while frozen. It also changes lapIdx while stop stays high, which catches a capture that is level-triggered: that design would overwrite a second slot. A capture into slot 7 followed by a reset checks that the clear reaches the whole memory and not only the counter.

// File: rtl/lapTimerPkg.sv
package lapTimerPkg;
  localparam int DIGIT_W = 4;
  localparam logic [DIGIT_W-1:0] DIGIT_MAX = 4'd9;

  // strobes from control to datapath
  typedef struct packed {
    logic advance;
    logic capture;
  } lapStrobes_t;
endpackage

// File: rtl/bcdDigit.sv
module bcdDigit
  import lapTimerPkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               carryIn,
  output logic [DIGIT_W-1:0] digit
);
  always_ff @(posedge clk) begin
    if (rst) begin
      digit <= '0;
    end else if (carryIn) begin
      if (digit == DIGIT_MAX) digit <= '0;
      else                    digit <= digit + 1'b1;
    end
  end
endmodule

// File: rtl/lapCtrl.sv
module lapCtrl
  import lapTimerPkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        tick,
  input  logic        stop,
  output lapStrobes_t strobes
);
  logic stopPrev;

  always_ff @(posedge clk) begin
    if (rst) stopPrev <= 1'b0;
    else     stopPrev <= stop;
  end

  always_comb begin
    strobes.advance = tick & ~stop;
    strobes.capture = stop & ~stopPrev;
  end
endmodule

// File: rtl/lapDatapath.sv
module lapDatapath
  import lapTimerPkg::*;
#(
  parameter int NUM_DIGITS = 3,
  parameter int LAP_SLOTS  = 8,
  parameter int IDX_W      = 3,
  localparam int BCD_W     = NUM_DIGITS * DIGIT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  lapStrobes_t      strobes,
  input  logic [IDX_W-1:0] lapIdx,
  input  logic [IDX_W-1:0] rdIdx,
  output logic [BCD_W-1:0] liveBcd,
  output logic [BCD_W-1:0] rdBcd
);
  logic [NUM_DIGITS-1:0] carry;
  logic [BCD_W-1:0]      laps [LAP_SLOTS];

  assign carry[0] = strobes.advance;

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : gDigit
    if (g > 0) begin : gCarry
      assign carry[g] = carry[g-1] & (liveBcd[(g-1)*DIGIT_W +: DIGIT_W] == DIGIT_MAX);
    end
    bcdDigit uDigit (
      .clk     (clk),
      .rst     (rst),
      .carryIn (carry[g]),
      .digit   (liveBcd[g*DIGIT_W +: DIGIT_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LAP_SLOTS; i++) laps[i] <= '0;
    end else if (strobes.capture) begin
      laps[lapIdx] <= liveBcd;
    end
  end

  assign rdBcd = laps[rdIdx];
endmodule

// File: rtl/lapTimer.sv
module lapTimer
  import lapTimerPkg::*;
#(
  parameter int NUM_DIGITS = 3,
  parameter int LAP_SLOTS  = 8,
  localparam int IDX_W     = $clog2(LAP_SLOTS),
  localparam int BCD_W     = NUM_DIGITS * DIGIT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             stop,
  input  logic [IDX_W-1:0] lapIdx,
  input  logic [IDX_W-1:0] rdIdx,
  output logic [BCD_W-1:0] liveBcd,
  output logic [BCD_W-1:0] rdBcd
);
  lapStrobes_t strobes;

  lapCtrl uCtrl (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .stop    (stop),
    .strobes (strobes)
  );

  lapDatapath #(
    .NUM_DIGITS (NUM_DIGITS),
    .LAP_SLOTS  (LAP_SLOTS),
    .IDX_W      (IDX_W)
  ) uPath (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .lapIdx  (lapIdx),
    .rdIdx   (rdIdx),
    .liveBcd (liveBcd),
    .rdBcd   (rdBcd)
  );
endmodule

// File: rtl/lapTimerChk.sv
module lapTimerChk
  import lapTimerPkg::*;
#(
  parameter int NUM_DIGITS = 3,
  parameter int LAP_SLOTS  = 8,
  localparam int IDX_W     = $clog2(LAP_SLOTS),
  localparam int BCD_W     = NUM_DIGITS * DIGIT_W
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic             stop,
  input logic [IDX_W-1:0] lapIdx,
  input logic [IDX_W-1:0] rdIdx,
  input logic [BCD_W-1:0] liveBcd,
  input logic [BCD_W-1:0] rdBcd
);
  function automatic logic [BCD_W-1:0] allNines();
    logic [BCD_W-1:0] r;
    for (int i = 0; i < NUM_DIGITS; i++) r[i*DIGIT_W +: DIGIT_W] = DIGIT_MAX;
    return r;
  endfunction
  localparam logic [BCD_W-1:0] TOP_COUNT = allNines();

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (liveBcd == '0) && (rdBcd == '0));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(liveBcd));

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : gRange
    // R2
    digit_range_chk: assert property (@(posedge clk) disable iff (rst)
      liveBcd[g*DIGIT_W +: DIGIT_W] <= DIGIT_MAX);
  end

  // R3
  ones_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !stop && liveBcd[DIGIT_W-1:0] == DIGIT_MAX) |=> (liveBcd[DIGIT_W-1:0] == '0));

  // R5
  wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !stop && liveBcd == TOP_COUNT) |=> (liveBcd == '0));

  // R6
  stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    stop |=> $stable(liveBcd));

  // R7
  lap_capture_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(stop) |=> (rdIdx != $past(lapIdx)) || (rdBcd == $past(liveBcd)));
endmodule

bind lapTimer lapTimerChk #(
  .NUM_DIGITS (NUM_DIGITS),
  .LAP_SLOTS  (LAP_SLOTS)
) uChk (
  .clk     (clk),
  .rst     (rst),
  .tick    (tick),
  .stop    (stop),
  .lapIdx  (lapIdx),
  .rdIdx   (rdIdx),
  .liveBcd (liveBcd),
  .rdBcd   (rdBcd)
);

// File: tb/lapTimer_test.sv
module lapTimer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        stop = 1'b0;
  logic [2:0]  lapIdx = '0;
  logic [2:0]  rdIdx = '0;
  logic [11:0] liveBcd;
  logic [11:0] rdBcd;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  lapTimer uut (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .stop    (stop),
    .lapIdx  (lapIdx),
    .rdIdx   (rdIdx),
    .liveBcd (liveBcd),
    .rdBcd   (rdBcd)
  );

  // {tick, stop, lapIdx[2:0], rdIdx[2:0], expLive[11:0], expRd[11:0]}
  localparam int NVEC = 7;
  localparam logic [31:0] VEC [NVEC] = '{
    32'h80001000,  // R2 first tick
    32'h00001000,  // R2 no tick holds
    32'h80002000,  // R2 second tick
    32'hDB002002,  // R6 R7 stop rises, slot 3 captured
    32'hED002000,  // R8 stop held, slot 5 untouched
    32'h83003002,  // R9 resume, slot 3 still readable
    32'h80004000   // R9 slot 0 unwritten
  };

  function automatic string rowTag(int r);
    case (r)
      0, 1, 2: return "R2";
      3:       return "R7";
      4:       return "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [11:0] toBcd(int c);
    return {4'(c / 100 % 10), 4'(c / 10 % 10), 4'(c % 10)};
  endfunction

  task automatic check(string tag, logic [11:0] act, logic [11:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive at negedge, let one posedge pass, return at next negedge
  task automatic step(logic t, logic s, logic [2:0] li, logic [2:0] ri);
    tick = t; stop = s; lapIdx = li; rdIdx = ri;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic tickN(int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 3'd0, rdIdx);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 live after reset", liveBcd, 12'h000);

    for (int r = 0; r < NVEC; r++) begin
      step(VEC[r][31], VEC[r][30], VEC[r][29:27], VEC[r][26:24]);
      check({rowTag(r), " live"}, liveBcd, VEC[r][23:12]);
      check({rowTag(r), " read"}, rdBcd, VEC[r][11:0]);
    end

    // count is 4 now
    tickN(5);
    check("R2 at 9", liveBcd, toBcd(9));
    tickN(1);
    check("R3 9 to 10", liveBcd, toBcd(10));
    tickN(89);
    check("R3 at 99", liveBcd, toBcd(99));
    tickN(1);
    check("R4 99 to 100", liveBcd, toBcd(100));
    tickN(899);
    check("R4 at 999", liveBcd, toBcd(999));

    step(1'b1, 1'b1, 3'd7, 3'd7);
    check("R6 frozen at 999", liveBcd, 12'h999);
    check("R7 slot 7 holds 999", rdBcd, 12'h999);
    step(1'b1, 1'b0, 3'd0, 3'd7);
    check("R5 wrap to 000", liveBcd, 12'h000);
    check("R9 slot 7 kept", rdBcd, 12'h999);
    rdIdx = 3'd3;
    #1;
    check("R9 comb read slot 3", rdBcd, 12'h002);

    // reset clears memory
    tickN(3);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 live cleared", liveBcd, 12'h000);
    for (int s = 0; s < 8; s++) begin
      rdIdx = 3'(s);
      #1;
      check("R1 slot cleared", rdBcd, 12'h000);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule